// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the target address of a memory operand from up to four parts: a base register value, an index register value shifted left by a 2-bit scale code, and a displacement that is sign-extended from 8, 16 or 32 bits. The register values come from a register file outside the block, together with the 3-bit codes of the registers that supplied them. Either register term can be switched off with a present flag. The two selector codes are checked against per-role lists of registers that may not be used. With the default lists, only the stack pointer (code 4) is barred, and only in the index role.

The sum is taken modulo 2^32. By default the result passes through one register stage that loads on an input strobe. The address and the fault flag then appear one cycle after the strobe, together with a valid output. A parameter removes the stage, and the outputs then follow the inputs combinationally. Reset is asserted asynchronously and released in step with the clock.

Top module: `scaled_ea_unit`

## Requirements
- R1: The target address is the base term plus the index term plus the extended displacement, modulo 2^32. A carry out of bit 31 is dropped and nothing reports it.
- R2: The index term is the index value shifted left by the scale code. Codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: The displacement size code selects the extension. Code 0 sign-extends bits [7:0], code 1 sign-extends bits [15:0], and codes 2 and 3 use all 32 bits. Bits above the selected width have no effect on the address.
- R4: When the base-present input is low, the base term is zero. When the index-present input is low, the index term is zero.
- R5: When index-present is high and the index selector is 4, the fault output is high and the index term is zero.
- R6: Any base selector from 0 to 7 is accepted without a fault. Any index selector other than 4 is accepted without a fault. With index-present low, the fault output stays low whatever the index selector is.
- R7: In the registered variant, the valid output is high exactly one cycle after a cycle with the input strobe high. The address and fault outputs change only after strobed cycles and hold their values otherwise.
- R8: During reset the valid output, the address and the fault flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads the output stage |
| base_sel | input | 3 | Register code that supplied the base value |
| base_en | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| index_sel | input | 3 | Register code that supplied the index value |
| index_en | input | 1 | Index term present |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Left shift applied to the index (0 to 3) |
| disp_raw | input | 32 | Displacement; only the low bits the size code selects are used |
| disp_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| out_valid | output | 1 | Address valid |
| target_addr | output | 32 | Computed target address |
| bad_index | output | 1 | Illegal index selector |

## Verification
The main sweep covers every scale code, every displacement size code and every index selector. It uses displacement words that are negative at 8 bits, at 16 bits or at 32 bits, and whose upper bits hold unrelated values. A wrong sign-extension width, a wrong shift or upper displacement bits leaking into the sum each produce a different address. Index values near 2^31 make the shifted index and the sum wrap, which separates modulo arithmetic from any saturation. Separate passes do the following:
- walk all four combinations of the present flags with a legal and an illegal index register;
- walk all base selectors;
- change inputs with the strobe low, to confirm that the outputs hold their values.

// File: rtl/ea_pkg.sv
package ea_pkg;
  // Displacement width codes; the extender decodes these values.
  typedef enum logic [1:0] {
    DSZ_BYTE = 2'd0,
    DSZ_HALF = 2'd1,
    DSZ_WORD = 2'd2,
    DSZ_WIDE = 2'd3
  } disp_size_e;

  localparam int BYTE_BITS = 8;
  localparam int HALF_BITS = 16;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic [AW-1:0] disp_raw,
  input  logic [1:0]    disp_size,
  output logic [AW-1:0] disp_ext
);
  localparam int BH = AW - BYTE_BITS;
  localparam int HH = AW - HALF_BITS;

  disp_size_e size_q;
  logic [AW-1:0] ext_byte, ext_half;

  always_comb begin
    size_q   = disp_size_e'(disp_size);
    ext_byte = {{BH{disp_raw[BYTE_BITS-1]}}, disp_raw[BYTE_BITS-1:0]};
    ext_half = {{HH{disp_raw[HALF_BITS-1]}}, disp_raw[HALF_BITS-1:0]};
    case (size_q)
      DSZ_BYTE: disp_ext = ext_byte;
      DSZ_HALF: disp_ext = ext_half;
      default:  disp_ext = disp_raw;
    endcase
  end

  // R3: a byte displacement keeps its low byte and fills above it with copies of one bit
  assert_disp_byte_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (disp_size == 2'd0) |-> (disp_ext[BYTE_BITS-1:0] == disp_raw[BYTE_BITS-1:0]) &&
      ((disp_ext[AW-1:BYTE_BITS-1] == '0) || (&disp_ext[AW-1:BYTE_BITS-1])));
  // R3: same rule at the halfword width
  assert_disp_half_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (disp_size == 2'd1) |-> (disp_ext[HALF_BITS-1:0] == disp_raw[HALF_BITS-1:0]) &&
      ((disp_ext[AW-1:HALF_BITS-1] == '0) || (&disp_ext[AW-1:HALF_BITS-1])));
endmodule

// File: rtl/ea_sel_check.sv
module ea_sel_check #(
  parameter int                   SELW      = 3,
  parameter logic [(1<<SELW)-1:0] BASE_BAN  = 8'h00,
  parameter logic [(1<<SELW)-1:0] INDEX_BAN = 8'h10
) (
  input  logic            clk,
  input  logic            rst_s,
  input  logic [SELW-1:0] base_sel,
  input  logic            base_en,
  input  logic [SELW-1:0] index_sel,
  input  logic            index_en,
  output logic            base_ok,
  output logic            index_ok,
  output logic            fault
);
  localparam int NREG = 1 << SELW;

  logic [NREG-1:0] base_hit, index_hit;

  // One decoder slice per register code; a slice flags only banned codes.
  for (genvar g = 0; g < NREG; g++) begin : g_code
    assign base_hit[g]  = (base_sel  == SELW'(g)) & BASE_BAN[g];
    assign index_hit[g] = (index_sel == SELW'(g)) & INDEX_BAN[g];
  end

  always_comb begin
    base_ok  = ~(|base_hit);
    index_ok = ~(|index_hit);
    fault    = (base_en & ~base_ok) | (index_en & ~index_ok);
  end

  // R5: a present index naming the stack pointer always faults and is not used
  assert_sp_index_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (index_en && index_sel == SELW'(4) && INDEX_BAN[4]) |-> (fault && !index_ok));
  // R6: with nothing present there can be no fault
  assert_no_terms_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!index_en && !base_en) |-> !fault);
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic           clk,
  input  logic           rst_s,
  input  logic [AW-1:0]  index_val,
  input  logic           index_use,
  input  logic [SCW-1:0] scale_code,
  output logic [AW-1:0]  scaled
);
  localparam int NSC = 1 << SCW;

  logic [AW-1:0] shifted [NSC];

  for (genvar g = 0; g < NSC; g++) begin : g_shift
    assign shifted[g] = index_val << g;
  end

  always_comb begin
    scaled = index_use ? shifted[scale_code] : '0;
  end

  // R2: scale code 0 passes the index through unchanged
  assert_unit_scale_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (index_use && scale_code == '0) |-> (scaled == index_val));
  // R2: scale code 1 gives twice the index
  assert_double_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (index_use && scale_code == SCW'(1)) |-> (scaled == index_val + index_val));
  // R4: an unused index term contributes nothing
  assert_idx_gate_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !index_use |-> (scaled == '0));
endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit #(
  parameter int                   AW         = 32,
  parameter int                   SELW       = 3,
  parameter int                   SCW        = 2,
  parameter bit                   REGISTERED = 1'b1,
  parameter logic [(1<<SELW)-1:0] BASE_BAN   = 8'h00,
  parameter logic [(1<<SELW)-1:0] INDEX_BAN  = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SELW-1:0] base_sel,
  input  logic            base_en,
  input  logic [AW-1:0]   base_val,
  input  logic [SELW-1:0] index_sel,
  input  logic            index_en,
  input  logic [AW-1:0]   index_val,
  input  logic [SCW-1:0]  scale_code,
  input  logic [AW-1:0]   disp_raw,
  input  logic [1:0]      disp_size,
  output logic            out_valid,
  output logic [AW-1:0]   target_addr,
  output logic            bad_index
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic          base_ok, index_ok, fault_d;
  logic [AW-1:0] disp_ext, idx_term, base_term, addr_d;

  ea_sel_check #(
    .SELW(SELW), .BASE_BAN(BASE_BAN), .INDEX_BAN(INDEX_BAN)
  ) u_sel (
    .clk(clk), .rst_s(rst_s),
    .base_sel(base_sel), .base_en(base_en),
    .index_sel(index_sel), .index_en(index_en),
    .base_ok(base_ok), .index_ok(index_ok), .fault(fault_d)
  );

  ea_index_scale #(.AW(AW), .SCW(SCW)) u_scale (
    .clk(clk), .rst_s(rst_s),
    .index_val(index_val), .index_use(index_en & index_ok),
    .scale_code(scale_code), .scaled(idx_term)
  );

  ea_disp_ext #(.AW(AW)) u_disp (
    .clk(clk), .rst_s(rst_s),
    .disp_raw(disp_raw), .disp_size(disp_size), .disp_ext(disp_ext)
  );

  always_comb begin
    base_term = (base_en & base_ok) ? base_val : '0;
    addr_d    = base_term + idx_term + disp_ext;  // carry out of the top bit is dropped
  end

  if (REGISTERED) begin : g_reg
    logic          vld_q, vld_n;
    logic [AW-1:0] addr_q, addr_n;
    logic          flt_q, flt_n;

    // Next-state: the strobe is the clock enable of the result register.
    always_comb begin
      vld_n  = in_valid;
      addr_n = in_valid ? addr_d  : addr_q;
      flt_n  = in_valid ? fault_d : flt_q;
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        flt_q  <= 1'b0;
      end else begin
        vld_q  <= vld_n;
        addr_q <= addr_n;
        flt_q  <= flt_n;
      end
    end

    assign out_valid   = vld_q;
    assign target_addr = addr_q;
    assign bad_index   = flt_q;

    // R7: valid follows the strobe by exactly one cycle
    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> out_valid);
    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_s)
      !in_valid |=> !out_valid);
    // R7: results hold when no strobe arrives
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_s)
      !in_valid |=> ($stable(target_addr) && $stable(bad_index)));
    // R5: a strobed stack-pointer index shows up as a fault
    assert_fault_out_R5: assert property (@(posedge clk) disable iff (!rst_s)
      (in_valid && index_en && index_sel == SELW'(4) && INDEX_BAN[4]) |=> bad_index);
  end else begin : g_comb
    assign out_valid   = in_valid;
    assign target_addr = addr_d;
    assign bad_index   = fault_d;
  end
endmodule

// File: tb/tb_scaled_ea_unit.sv
module tb_scaled_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  base_sel, index_sel;
  logic        base_en, index_en;
  logic [31:0] base_val, index_val, disp_raw;
  logic [1:0]  scale_code, disp_size;
  logic        out_valid, bad_index;
  logic [31:0] target_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_ea_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_sel(base_sel), .base_en(base_en), .base_val(base_val),
    .index_sel(index_sel), .index_en(index_en), .index_val(index_val),
    .scale_code(scale_code), .disp_raw(disp_raw), .disp_size(disp_size),
    .out_valid(out_valid), .target_addr(target_addr), .bad_index(bad_index)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(
    input logic be, input logic [31:0] bv, input logic ie, input logic [2:0] is,
    input logic [31:0] iv, input logic [1:0] sc, input logic [31:0] d, input logic [1:0] ds);
    logic [31:0] dx, it, bt;
    case (ds)
      2'd0:    dx = 32'($signed(d[7:0]));
      2'd1:    dx = 32'($signed(d[15:0]));
      default: dx = d;
    endcase
    it = (ie && is != 3'd4) ? iv * (32'd1 << sc) : 32'd0;
    bt = be ? bv : 32'd0;
    return bt + it + dx;
  endfunction

  // Strobe one request and check the registered result one cycle later.
  task automatic issue(input string req, input logic be, input logic [2:0] bs,
    input logic [31:0] bv, input logic ie, input logic [2:0] is, input logic [31:0] iv,
    input logic [1:0] sc, input logic [31:0] d, input logic [1:0] ds);
    @(negedge clk);
    in_valid = 1'b1; base_en = be; base_sel = bs; base_val = bv;
    index_en = ie; index_sel = is; index_val = iv;
    scale_code = sc; disp_raw = d; disp_size = ds;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " addr"}, target_addr, ref_addr(be, bv, ie, is, iv, sc, d, ds));
    check({req, " fault"}, {31'd0, bad_index}, {31'd0, (ie && is == 3'd4)});
    check("R7 valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] dvals [4];
    logic [31:0] held;
    dvals[0] = 32'hABCD_EF80;  // negative at 8 and 16 bits, junk above
    dvals[1] = 32'h1234_007F;  // positive at 8 and 16
    dvals[2] = 32'h8000_8001;  // positive at 8, negative at 16 and 32
    dvals[3] = 32'hF00F_7FF0;  // negative at 8, positive at 16

    rst_n = 1'b0; in_valid = 1'b0;
    base_en = 1'b0; base_sel = '0; base_val = '0;
    index_en = 1'b0; index_sel = '0; index_val = '0;
    scale_code = '0; disp_raw = '0; disp_size = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;  // ignored while in reset
    @(negedge clk);
    check("R8 reset valid", {31'd0, out_valid}, 32'd0);
    check("R8 reset addr", target_addr, 32'd0);
    check("R8 reset fault", {31'd0, bad_index}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle after reset", {31'd0, out_valid}, 32'd0);

    // R1 R2 R3 R5: all scales, sizes, displacement patterns and index codes
    for (int sc = 0; sc < 4; sc++)
      for (int ds = 0; ds < 4; ds++)
        for (int di = 0; di < 4; di++)
          for (int is = 0; is < 8; is++)
            issue("R1/R2/R3/R5 sweep", 1'b1, 3'(is ^ 3), 32'h1000_0400 + 32'(di * 64),
                  1'b1, 3'(is), 32'h7FFF_FFF0 + 32'(is * 5), 2'(sc), dvals[di], 2'(ds));

    // R1: wrap modulo 2^32 with no other indication
    issue("R1 wrap", 1'b1, 3'd0, 32'hFFFF_FFF0, 1'b0, 3'd1, 32'h0, 2'd0, 32'h0000_0020, 2'd2);
    issue("R1 wrap scaled", 1'b1, 3'd7, 32'h8000_0000, 1'b1, 3'd3, 32'h9000_0001, 2'd3,
          32'hFFFF_FFFF, 2'd2);

    // R4: present flags, with a legal and an illegal index code
    for (int m = 0; m < 4; m++) begin
      issue("R4 present legal", m[0], 3'd5, 32'h0001_0000, m[1], 3'd2, 32'h0000_0100, 2'd2,
            32'h0000_00F0, 2'd0);
      issue("R4/R5 present sp", m[0], 3'd5, 32'h0001_0000, m[1], 3'd4, 32'h0000_0100, 2'd2,
            32'h0000_00F0, 2'd0);
    end

    // R6: every base code, and the stack pointer as base, never faults
    for (int bs = 0; bs < 8; bs++)
      issue("R6 base code", 1'b1, 3'(bs), 32'h2000_0000 + 32'(bs), 1'b0, 3'd4, 32'hFFFF_FFFF,
            2'd1, 32'h0000_8000, 2'd1);

    // R7: outputs hold while the strobe is low
    held = target_addr;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      base_en = 1'b1; base_val = 32'h5555_0000 + 32'(k);
      index_en = 1'b1; index_sel = 3'd4;
      @(posedge clk);
      @(negedge clk);
      check("R7 hold addr", target_addr, held);
      check("R7 hold fault", {31'd0, bad_index}, 32'd0);
      check("R7 no valid", {31'd0, out_valid}, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule